// File: doc/BRIEF.md
# Single-Bit Drift Stabilizer

This block holds a free-running oscillator on frequency by repeatedly measuring it against a stable reference clock. A timer built from the reference clock opens a counting window of fixed length, and the oscillator's rising edges are counted while the window is open. After the window closes, three timed phases follow in a fixed order. The first phase is a settling pause. The second phase captures one chosen low-order bit of the count into a flip-flop. The third phase clears the counter. The next window then opens.

The flip-flop output drives an external RC integrator, and the integrator's voltage steers the oscillator. A captured 0 sets the drive high, which pushes the frequency up. A captured 1 sets the drive low, which pulls it down. The loop settles by flipping back and forth around the count at which the chosen bit changes value. The position of that bit sets the spacing of the tuning grid.

The oscillator input must already be synchronous to the reference clock. An edge counts when two consecutive clock samples read 0 and then 1. The integrator and any analogue parts are outside this block.

Top module: `hp_stabilizer`

## Requirements
- R1: After reset `gate_o` is 1. It then stays high for GATE_LEN clock cycles and low for 3*PULSE_LEN clock cycles, and this repeats.
- R2: The counter adds one for each clock cycle in which `gate_o` is 1 and `osc_in` is 1 after having been 0 at the previous clock sample. Edges seen while `gate_o` is 0 are not counted.
- R3: `drive_o` takes its new value at the (PULSE_LEN+1)-th rising clock edge after the edge at which `gate_o` fell. It keeps its old value at the PULSE_LEN-th edge.
- R4: The new `drive_o` value is 1 when bit SAMPLE_BIT (bit 0 = least significant) of the window's edge count is 0, and it is 0 when that bit is 1.
- R5: `drive_o` is 0 after reset and changes only at the capture edge of R3.
- R6: The counter is cleared during the third phase, so each window's count starts from zero whatever earlier windows counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_in | input | 1 | Oscillator signal, already synchronous to `clk` |
| drive_o | output | 1 | Up/down level for the external integrator |
| gate_o | output | 1 | Counting window, brought out for debug |

## Verification
The assertions assume that `osc_in` is sampled only at clock edges and that it changes at most once per clock cycle. They also assume that reset is held for at least one edge before any window is judged. The stimulus changes `osc_in` shortly after each rising edge. It uses square waves of several periods, a held level, and a mode that toggles only while the window is closed. That last mode exposes edges that land outside the window and would wrongly be counted. The expected drive level comes from a model that counts edges against the observed `gate_o`.

// File: rtl/hp_pkg.sv
package hp_pkg;

    // Phases of one measurement cycle, in the order they run.
    typedef enum logic [1:0] {
        PH_GATE  = 2'd0,
        PH_ARM   = 2'd1,
        PH_LATCH = 2'd2,
        PH_CLEAR = 2'd3
    } hp_phase_e;

    // Control strobes decoded from the phase sequencer.
    typedef struct packed {
        logic gate;    // counting window open
        logic arm;     // first one-shot: settling pause
        logic latch;   // single-cycle capture strobe
        logic clear;   // third one-shot: counter held at zero
    } hp_strobe_s;

    function automatic hp_phase_e hp_next_phase(input hp_phase_e cur);
        case (cur)
            PH_GATE:  return PH_ARM;
            PH_ARM:   return PH_LATCH;
            PH_LATCH: return PH_CLEAR;
            default:  return PH_GATE;
        endcase
    endfunction

    function automatic int hp_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hp_phase_seq.sv
module hp_phase_seq
    import hp_pkg::*;
#(
    parameter int GATE_LEN  = 200,
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    output hp_strobe_s strobe_o
);
    localparam int MAXLEN = hp_max(GATE_LEN, PULSE_LEN);
    localparam int TW     = $clog2(MAXLEN + 1);

    hp_phase_e    phase_q;
    logic [TW-1:0] timer_q;
    logic [TW-1:0] limit;
    logic          last_tick;

    always_comb begin
        limit     = (phase_q == PH_GATE) ? TW'(GATE_LEN - 1) : TW'(PULSE_LEN - 1);
        last_tick = (timer_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_GATE;
            timer_q <= '0;
        end else if (last_tick) begin
            phase_q <= hp_next_phase(phase_q);
            timer_q <= '0;
        end else begin
            timer_q <= timer_q + 1'b1;
        end
    end

    always_comb begin
        strobe_o.gate  = (phase_q == PH_GATE);
        strobe_o.arm   = (phase_q == PH_ARM);
        strobe_o.latch = (phase_q == PH_LATCH) && (timer_q == '0);
        strobe_o.clear = (phase_q == PH_CLEAR);
    end

    // R1: the window closes only after its full length
    assert_gate_len_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_o.gate) |-> ($past(timer_q) == TW'(GATE_LEN - 1)));

    // R3: capture strobe follows the end of the settling phase
    assert_latch_after_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (strobe_o.arm && last_tick) |=> strobe_o.latch);

    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobe_o.gate, strobe_o.arm, strobe_o.clear}));

endmodule

// File: rtl/hp_edge_det.sv
module hp_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/hp_cycle_counter.sv
module hp_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) count_q <= '0;
        else if (inc_i)   count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    // R2: no change without a counted edge
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !clr_i) |=> $stable(count_o));

    // R2: one step per counted edge
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (count_o == $past(count_o) + 1'b1));

    // R6: clear phase leaves the counter at zero
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_o == '0));

endmodule

// File: rtl/hp_bit_latch.sv
module hp_bit_latch #(
    parameter int CNT_W      = 16,
    parameter int SAMPLE_BIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             drive_o
);
    logic drive_q;

    always_ff @(posedge clk) begin
        if (rst)         drive_q <= 1'b0;
        else if (take_i) drive_q <= ~count_i[SAMPLE_BIT];
    end

    assign drive_o = drive_q;

    // R4: captured level is the inverse of the selected bit
    assert_polarity_R4: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (drive_o == ~$past(count_i[SAMPLE_BIT])));

    // R5: level held between captures
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(drive_o));

endmodule

// File: rtl/hp_stabilizer.sv
module hp_stabilizer
    import hp_pkg::*;
#(
    parameter int GATE_LEN   = 200,
    parameter int PULSE_LEN  = 4,
    parameter int CNT_W      = 16,
    parameter int SAMPLE_BIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    output logic drive_o,
    output logic gate_o
);
    hp_strobe_s       strobe;
    logic             osc_rise;
    logic             count_en;
    logic [CNT_W-1:0] count;

    hp_phase_seq #(
        .GATE_LEN (GATE_LEN),
        .PULSE_LEN(PULSE_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .strobe_o(strobe)
    );

    hp_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .sig_i (osc_in),
        .rise_o(osc_rise)
    );

    assign count_en = strobe.gate & osc_rise;

    hp_cycle_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (count_en),
        .clr_i  (strobe.clear),
        .count_o(count)
    );

    hp_bit_latch #(
        .CNT_W     (CNT_W),
        .SAMPLE_BIT(SAMPLE_BIT)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .take_i (strobe.latch),
        .count_i(count),
        .drive_o(drive_o)
    );

    assign gate_o = strobe.gate;

    // R2: closed window never lets the count move, except by clearing
    assert_no_count_closed_R2: assert property (@(posedge clk) disable iff (rst)
        (!gate_o && !strobe.clear) |=> $stable(count));

endmodule

// File: tb/hp_stabilizer_tb_top.sv
module hp_stabilizer_tb_top;
    localparam int GATE_LEN   = 200;
    localparam int PULSE_LEN  = 4;
    localparam int CNT_W      = 16;
    localparam int SAMPLE_BIT = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_in = 1'b0;
    logic drive_o, gate_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    hp_stabilizer #(
        .GATE_LEN(GATE_LEN), .PULSE_LEN(PULSE_LEN),
        .CNT_W(CNT_W), .SAMPLE_BIT(SAMPLE_BIT)
    ) dut_i (
        .clk(clk), .rst(rst), .osc_in(osc_in),
        .drive_o(drive_o), .gate_o(gate_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Stimulus: 0 = held low, 1 = square wave of period osc_per, 2 = toggle only while closed
    int osc_mode = 0;
    int osc_per  = 5;
    int osc_ph   = 0;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            case (osc_mode)
                1: begin
                    osc_ph = (osc_ph + 1) % osc_per;
                    osc_in = (osc_ph < osc_per / 2);
                end
                2: if (!gate_o) osc_in = ~osc_in;
                default: osc_in = 1'b0;
            endcase
        end
    end

    // Scoreboard
    logic exp_q[$];
    int   model_cnt  = 0;
    logic prev_b     = 1'b0;
    logic gate_b     = 1'b1;
    int   high_run   = 0;
    int   low_run    = 0;
    int   fall_age   = -1;
    logic last_drive = 1'b0;
    int   windows    = 0;
    bit   first_fall = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            // model of R2: edge counted in cycles with the window open
            if (gate_o && osc_in && !prev_b) model_cnt++;

            if (gate_b && !gate_o) begin
                check_int("R1 window high length", high_run, GATE_LEN);
                exp_q.push_back(~model_cnt[SAMPLE_BIT]);   // R4 expected level
                fall_age = 0;
                low_run  = 1;
                first_fall = 1'b0;
            end else if (!gate_b && gate_o) begin
                check_int("R1 window low length", low_run, 3 * PULSE_LEN);
                model_cnt = (osc_in && !prev_b) ? 1 : 0;   // R6 fresh count
                high_run  = 1;
            end else if (gate_o) begin
                high_run++;
            end else begin
                low_run++;
            end

            if (fall_age == PULSE_LEN)
                check("R3 R5 drive held before capture edge", drive_o, last_drive);
            if (fall_age == PULSE_LEN + 1) begin
                logic e;
                e = exp_q.pop_front();
                check("R3 R4 R6 captured drive level", drive_o, e);
                last_drive = drive_o;
                windows++;
            end
            if (fall_age >= 0) fall_age++;
            gate_b = gate_o;
        end
        prev_b = osc_in;
    end

    task automatic run_windows(input int n);
        int start;
        start = windows;
        while (windows < start + n) @(posedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 gate high after reset", gate_o, 1'b1);
        check("R5 drive low after reset", drive_o, 1'b0);

        osc_mode = 0;  run_windows(2);      // no edges: bit 0, drive 1
        osc_mode = 1; osc_per = 5;  run_windows(2);
        osc_per = 7;   run_windows(2);
        osc_per = 11;  run_windows(2);
        osc_per = 13;  run_windows(2);
        osc_per = 6;   run_windows(1);
        osc_mode = 2;  run_windows(3);      // R2 edges only while closed
        osc_mode = 1; osc_per = 9;  run_windows(2);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule